// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block holds the characters that a UART deserializer has assembled until host software reads them. In queued mode it is a 16-entry first-in first-out store that flags overrun on a full push and raises a threshold signal once the occupancy reaches a programmable trigger level. It also reports data-ready and break status. A character-timeout timer counts the prescaled bit-rate tick and raises a pending flag when data has sat unread for four character times. With queueing switched off, the block falls back to one holding register.

Character framing (data length, parity present, stop-bit count) sets the length of a character time and so the timer period. The timer is a three-state machine. `TMR_IDLE` is stopped. `TMR_COUNT` is loaded and counting ticks. `TMR_FIRE` is a one-cycle expiry state. Its transitions are arm (any state to `TMR_COUNT`, with reload), stop (any state to `TMR_IDLE`), expire (`TMR_COUNT` to `TMR_FIRE` on the last tick) and retire (`TMR_FIRE` to `TMR_IDLE`). Stop outranks arm, and arm outranks the others.

Top module: `rxq_buffer`

## Requirements
- R1: With `fifo_en` high, up to 16 characters are held and popped in arrival order. `level` gives the occupancy, from 0 to 16.
- R2: A push into a full queue with no pop in the same cycle discards the byte and sets `overrun`. A push and a pop in the same cycle on a full queue both succeed and do not set `overrun`. A `status_ack` pulse clears `overrun` and `brk_flag`.
- R3: `trig_sel` 00, 01, 10 and 11 select trigger levels of 1, 4, 8 and 14 entries. `above_trig` is high while `level` is at or above the selected level.
- R4: A character time is 1 start bit + (5 + `fmt_len`) data bits + 1 bit if `fmt_par` + (2 if `fmt_two_stop` else 1) stop bits. The timer period is four character times, counted in `baud_tick` pulses. Each accepted or attempted arrival restarts the timer, and so does each pop that leaves the queue non-empty.
- R5: At expiry, `tmo_pend` is set only if the queue still holds data, one clock after the last tick. Any pop in queued mode clears it.
- R6: In queued mode, `rd_data` reads zero while the queue is empty. A pop that empties the queue clears `data_ready` and `brk_flag`.
- R7: A `rx_reset` pulse empties the queue and clears `data_ready`, `brk_flag` and `tmo_pend`. It also stops the timer, so no later expiry occurs without a new arrival.
- R8: A change of `fifo_en` flushes the receive store as in R7. In that same cycle it drives `tx_flush_req` high so that the transmit side is flushed as well.
- R9: A `brk_valid` pulse stores a zero byte and sets `brk_flag` and `data_ready`. It takes precedence over a simultaneous `push_valid`.
- R10: With `fifo_en` low, one holding register is used and `level` reads 1 while it is full. A new arrival while `data_ready` is set replaces the byte and sets `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queued mode select |
| rx_reset | input | 1 | Receive store flush pulse |
| trig_sel | input | 2 | Trigger level select |
| fmt_len | input | 2 | Data length minus five |
| fmt_par | input | 1 | Parity bit present |
| fmt_two_stop | input | 1 | Two stop bits |
| baud_tick | input | 1 | One pulse per bit time |
| push_valid | input | 1 | Character arrival strobe |
| push_data | input | 8 | Arriving character |
| brk_valid | input | 1 | Break arrival strobe |
| pop | input | 1 | Host read strobe |
| status_ack | input | 1 | Host status read, clears overrun and break |
| rd_data | output | 8 | Character presented to the host |
| level | output | 5 | Occupancy |
| data_ready | output | 1 | Data available |
| brk_flag | output | 1 | Break received |
| overrun | output | 1 | Character lost |
| above_trig | output | 1 | Occupancy at or above trigger |
| tmo_pend | output | 1 | Character timeout pending |
| tx_flush_req | output | 1 | Transmit flush request |

## Verification
The properties assume that the strobes `push_valid`, `brk_valid`, `pop`, `rx_reset` and `status_ack` are clean synchronous levels that are sampled once per clock. They do not assume that the strobes are mutually exclusive. The properties reason about one cycle after a flush, even when `fifo_en` toggles again in that cycle. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It changes `fifo_en` only inside a dedicated task, and it pulses `baud_tick` with idle cycles between pulses, so each tick is counted once.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_FIRE  = 2'd2
    } tmr_state_e;

    // trigger field to entry count
    function automatic int unsigned trig_entries(input logic [1:0] sel);
        int unsigned n;
        unique case (sel)
            2'b00:   n = 1;
            2'b01:   n = 4;
            2'b10:   n = 8;
            default: n = 14;
        endcase
        return n;
    endfunction

    // bits in one serial character: start + data + parity + stop
    function automatic int unsigned frame_bits(input logic [1:0] len,
                                               input logic       par,
                                               input logic       two_stop);
        return 32'd6 + 32'(len) + (par ? 32'd1 : 32'd0) + (two_stop ? 32'd2 : 32'd1);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] head,
    output logic [CW-1:0] fill
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    always_comb begin
        fill = fill_q;
        head = (fill_q == '0) ? '0 : mem[rd_ptr];
    end

endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer
    import rxq_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop,
    input  logic          arm,
    input  logic          tick,
    input  logic [TW-1:0] reload,
    output logic          fire
);
    tmr_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (stop) begin
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end else if (arm) begin
            state_d = TMR_COUNT;
            cnt_d   = reload;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    state_d = TMR_IDLE;
                end
                TMR_COUNT: begin
                    if (tick) begin
                        if (cnt_q <= TW'(1)) begin
                            state_d = TMR_FIRE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                TMR_FIRE: begin
                    state_d = TMR_IDLE;
                end
                default: begin
                    state_d = TMR_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        fire = (state_q == TMR_FIRE);
    end

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DW        = 8,
    parameter int TMO_CHARS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic                         rx_reset,
    input  logic [1:0]                   trig_sel,
    input  logic [1:0]                   fmt_len,
    input  logic                         fmt_par,
    input  logic                         fmt_two_stop,
    input  logic                         baud_tick,
    input  logic                         push_valid,
    input  logic [DW-1:0]                push_data,
    input  logic                         brk_valid,
    input  logic                         pop,
    input  logic                         status_ack,
    output logic [DW-1:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         data_ready,
    output logic                         brk_flag,
    output logic                         overrun,
    output logic                         above_trig,
    output logic                         tmo_pend,
    output logic                         tx_flush_req
);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int MAX_BIT = 12;
    localparam int TW      = $clog2(TMO_CHARS * MAX_BIT + 1);

    logic          fifo_en_q;
    logic          rx_flush;
    logic          arrive;
    logic [DW-1:0] in_byte;
    logic [DW-1:0] f_head;
    logic [CNT_W-1:0] f_fill;
    logic          f_empty, f_full;
    logic          pop_ok, wr_ok, ovr_set, empties;
    logic          hold_full;
    logic [DW-1:0] hold_q;
    logic          brk_q, ovr_q, pend_q;
    logic          tmr_arm, tmr_fire;
    logic [TW-1:0] tmr_reload;

    // mode tracking and flush generation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_en_q <= 1'b0;
        else        fifo_en_q <= fifo_en;
    end

    always_comb begin
        tx_flush_req = fifo_en ^ fifo_en_q;
        rx_flush     = rx_reset | tx_flush_req;
        arrive       = push_valid | brk_valid;
        in_byte      = brk_valid ? '0 : push_data;
        f_empty      = (f_fill == '0);
        f_full       = (f_fill == CNT_W'(DEPTH));
        pop_ok       = fifo_en & pop & ~f_empty & ~rx_flush;
        wr_ok        = fifo_en & arrive & ~rx_flush & (~f_full | pop_ok);
        if (fifo_en)
            ovr_set = ~rx_flush & arrive & f_full & ~pop_ok;
        else
            ovr_set = ~rx_flush & arrive & hold_full & ~pop;
        if (fifo_en)
            empties = pop_ok & (f_fill == CNT_W'(1)) & ~wr_ok;
        else
            empties = ~rx_flush & pop & hold_full & ~arrive;
    end

    rxq_store #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .CW    (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .wr_en   (wr_ok),
        .wr_data (in_byte),
        .rd_en   (pop_ok),
        .head    (f_head),
        .fill    (f_fill)
    );

    // single holding register used when queueing is off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (rx_flush) begin
            hold_full <= 1'b0;
        end else if (!fifo_en) begin
            if (arrive) begin
                hold_q    <= in_byte;
                hold_full <= 1'b1;
            end else if (pop) begin
                hold_full <= 1'b0;
            end
        end
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (rx_flush)                    brk_q <= 1'b0;
            else if (brk_valid)              brk_q <= 1'b1;
            else if (status_ack || empties)  brk_q <= 1'b0;

            if (ovr_set)                     ovr_q <= 1'b1;
            else if (status_ack)             ovr_q <= 1'b0;
        end
    end

    // character timeout
    always_comb begin
        tmr_reload = TW'(TMO_CHARS * frame_bits(fmt_len, fmt_par, fmt_two_stop));
        tmr_arm    = fifo_en & ~rx_flush &
                     (arrive | (pop_ok & (f_fill > CNT_W'(1))));
    end

    rxq_char_timer #(
        .TW (TW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .stop   (rx_flush),
        .arm    (tmr_arm),
        .tick   (baud_tick),
        .reload (tmr_reload),
        .fire   (tmr_fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    pend_q <= 1'b0;
        else if (rx_flush)             pend_q <= 1'b0;
        else if (fifo_en && pop)       pend_q <= 1'b0;
        else if (tmr_fire && !f_empty) pend_q <= 1'b1;
    end

    // outputs
    always_comb begin
        if (fifo_en) begin
            rd_data    = f_head;
            level      = f_fill;
            data_ready = ~f_empty;
            above_trig = (32'(f_fill) >= trig_entries(trig_sel));
        end else begin
            rd_data    = hold_q;
            level      = CNT_W'(hold_full);
            data_ready = hold_full;
            above_trig = hold_full;
        end
        brk_flag = brk_q;
        overrun  = ovr_q;
        tmo_pend = pend_q;
    end

endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             flush,
    input logic             push_valid,
    input logic             brk_valid,
    input logic             pop,
    input logic [CNT_W-1:0] level,
    input logic             data_ready,
    input logic             brk_flag,
    input logic             overrun,
    input logic             tmo_pend
);

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && !flush && (push_valid || brk_valid) && level == CNT_W'(DEPTH) && !pop
        |=> overrun);

    p_full_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && !flush && push_valid && level == CNT_W'(DEPTH) && pop && !overrun
        |=> !overrun);

    p_pend_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_pend) |-> level != '0);

    p_read_clears_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && pop |=> !tmo_pend);

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && !flush && pop && level == CNT_W'(1) && !push_valid && !brk_valid
        |=> !brk_flag && !data_ready);

    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0 && !data_ready && !tmo_pend && !brk_flag);

    p_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && brk_valid |=> brk_flag);

    p_single_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en && !flush && push_valid && data_ready && !pop |=> overrun);

endmodule

bind rxq_buffer rxq_buffer_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .flush      (rx_flush),
    .push_valid (push_valid),
    .brk_valid  (brk_valid),
    .pop        (pop),
    .level      (level),
    .data_ready (data_ready),
    .brk_flag   (brk_flag),
    .overrun    (overrun),
    .tmo_pend   (tmo_pend)
);

// File: tb/rxq_buffer_test.sv
module rxq_buffer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, rx_reset = 1'b0;
    logic [1:0] trig_sel = 2'b00, fmt_len = 2'b11;
    logic       fmt_par = 1'b0, fmt_two_stop = 1'b0, baud_tick = 1'b0;
    logic       push_valid = 1'b0, brk_valid = 1'b0, pop = 1'b0, status_ack = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_ready, brk_flag, overrun, above_trig, tmo_pend, tx_flush_req;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxq_buffer uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_reset(rx_reset),
        .trig_sel(trig_sel), .fmt_len(fmt_len), .fmt_par(fmt_par),
        .fmt_two_stop(fmt_two_stop), .baud_tick(baud_tick),
        .push_valid(push_valid), .push_data(push_data), .brk_valid(brk_valid),
        .pop(pop), .status_ack(status_ack), .rd_data(rd_data), .level(level),
        .data_ready(data_ready), .brk_flag(brk_flag), .overrun(overrun),
        .above_trig(above_trig), .tmo_pend(tmo_pend), .tx_flush_req(tx_flush_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk) push_valid = 1'b1; push_data = d;
        @(negedge clk) push_valid = 1'b0;
    endtask

    task automatic send_break();
        @(negedge clk) brk_valid = 1'b1;
        @(negedge clk) brk_valid = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input int exp);
        @(negedge clk);
        chk(tag, int'(rd_data), exp);
        pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk) status_ack = 1'b1;
        @(negedge clk) status_ack = 1'b0;
    endtask

    task automatic flush_rx();
        @(negedge clk) rx_reset = 1'b1;
        @(negedge clk) rx_reset = 1'b0;
        ack();
    endtask

    task automatic set_mode(input logic en);
        @(negedge clk) fifo_en = en;
        #1 chk("R8 tx_flush_req on toggle", int'(tx_flush_req), 1);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) baud_tick = 1'b1;
            @(negedge clk) baud_tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset level", int'(level), 0);
        chk("R6 reset data_ready", int'(data_ready), 0);
        chk("R2 reset overrun", int'(overrun), 0);
        chk("R5 reset tmo_pend", int'(tmo_pend), 0);
        chk("R9 reset brk_flag", int'(brk_flag), 0);
    endtask

    task automatic t_order();
        set_mode(1'b1);
        trig_sel = 2'b11;
        for (int i = 0; i < 16; i++) begin
            push(8'(i * 7 + 3));
            if (i == 12) chk("R3 below 14", int'(above_trig), 0);
            if (i == 13) chk("R3 at 14", int'(above_trig), 1);
        end
        chk("R1 full level", int'(level), 16);
        push(8'hEE);
        chk("R2 overrun on full push", int'(overrun), 1);
        chk("R2 level after drop", int'(level), 16);
        ack();
        chk("R2 ack clears overrun", int'(overrun), 0);
        for (int i = 0; i < 16; i++) pop_chk("R1 order", (i * 7 + 3) & 8'hFF);
        @(negedge clk);
        chk("R6 data_ready after emptying", int'(data_ready), 0);
        chk("R6 empty read zero", int'(rd_data), 0);
        pop_chk("R6 pop empty returns zero", 0);
        chk("R1 level stays zero", int'(level), 0);
    endtask

    task automatic t_trig();
        int lv [4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            flush_rx();
            trig_sel = 2'(s);
            for (int k = 0; k < lv[s] - 1; k++) push(8'(k));
            chk("R3 one below trigger", int'(above_trig), 0);
            push(8'hA5);
            chk("R3 at trigger", int'(above_trig), 1);
        end
        flush_rx();
    endtask

    task automatic t_full_swap();
        for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
        @(negedge clk);
        chk("R2 head before swap", int'(rd_data), 8'h40);
        push_valid = 1'b1; push_data = 8'h99; pop = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; pop = 1'b0;
        chk("R2 swap level", int'(level), 16);
        chk("R2 swap no overrun", int'(overrun), 0);
        for (int i = 1; i < 16; i++) pop_chk("R2 order after swap", 8'h40 + i);
        pop_chk("R2 swapped byte last", 8'h99);
    endtask

    task automatic t_timeout();
        flush_rx();
        fmt_len = 2'b11; fmt_par = 1'b0; fmt_two_stop = 1'b0;   // 10 bits, 40 ticks
        push(8'h11);
        ticks(39);
        chk("R4 no pend before 40 ticks", int'(tmo_pend), 0);
        ticks(1);
        chk("R4 pend after 40 ticks", int'(tmo_pend), 1);
        pop_chk("R5 data", 8'h11);
        chk("R5 pop clears pend", int'(tmo_pend), 0);
        push(8'h21); push(8'h22);
        ticks(30);
        pop_chk("R4 partial read", 8'h21);
        ticks(39);
        chk("R4 read rearms (before)", int'(tmo_pend), 0);
        ticks(1);
        chk("R4 read rearms (after)", int'(tmo_pend), 1);
        pop_chk("R4 rest", 8'h22);
        push(8'h31);
        ticks(30);
        push(8'h32);
        ticks(39);
        chk("R4 arrival rearms (before)", int'(tmo_pend), 0);
        ticks(1);
        chk("R4 arrival rearms (after)", int'(tmo_pend), 1);
        pop_chk("R4 a", 8'h31); pop_chk("R4 b", 8'h32);
        fmt_len = 2'b00; fmt_par = 1'b1; fmt_two_stop = 1'b1;   // 9 bits, 36 ticks
        push(8'h44);
        ticks(35);
        chk("R4 short frame before", int'(tmo_pend), 0);
        ticks(1);
        chk("R4 short frame after", int'(tmo_pend), 1);
        pop_chk("R4 c", 8'h44);
        fmt_len = 2'b11; fmt_par = 1'b0; fmt_two_stop = 1'b0;
    endtask

    task automatic t_expire_empty();
        flush_rx();
        push(8'h55);
        ticks(20);
        pop_chk("R5 drain", 8'h55);
        ticks(25);
        chk("R5 expiry while empty", int'(tmo_pend), 0);
    endtask

    task automatic t_flush();
        push(8'h01); push(8'h02); push(8'h03);
        send_break();
        ticks(10);
        @(negedge clk) rx_reset = 1'b1;
        @(negedge clk) rx_reset = 1'b0;
        chk("R7 level", int'(level), 0);
        chk("R7 data_ready", int'(data_ready), 0);
        chk("R7 brk_flag", int'(brk_flag), 0);
        ticks(45);
        chk("R7 timer stopped", int'(tmo_pend), 0);
    endtask

    task automatic t_break();
        flush_rx();
        send_break();
        chk("R9 brk_flag", int'(brk_flag), 1);
        chk("R9 data_ready", int'(data_ready), 1);
        chk("R9 level", int'(level), 1);
        chk("R9 zero byte", int'(rd_data), 0);
        ack();
        chk("R2 ack clears break", int'(brk_flag), 0);
        send_break();
        pop_chk("R9 zero popped", 0);
        pop_chk("R6 drain", 0);
        chk("R6 emptying read clears break", int'(brk_flag), 0);
        chk("R6 emptying read clears ready", int'(data_ready), 0);
    endtask

    task automatic t_toggle_single();
        push(8'h77); push(8'h78);
        set_mode(1'b0);
        chk("R8 flushed level", int'(level), 0);
        chk("R8 flushed ready", int'(data_ready), 0);
        push(8'hA1);
        chk("R10 ready", int'(data_ready), 1);
        chk("R10 level one", int'(level), 1);
        chk("R10 data", int'(rd_data), 8'hA1);
        push(8'hB2);
        chk("R10 overrun", int'(overrun), 1);
        chk("R10 replaced", int'(rd_data), 8'hB2);
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
        chk("R10 read clears ready", int'(data_ready), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_trig();
        t_full_swap();
        t_timeout();
        t_expire_empty();
        t_flush();
        t_break();
        t_toggle_single();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule